// File: doc/BRIEF.md
# Load/Store Address and Lane Unit

This block sits in the memory stage of a 32-bit big-endian load/store pipe. For each access it takes a size (byte, half-word or word) and an address that is either a full effective address or an 8-bit direct operand. From these it forms the aligned data address, the per-byte write strobes and a write word whose bytes sit in the correct lanes. An address that is not aligned to the access size is quietly rounded down to the size boundary. No exception is raised. A direct operand is scaled by the access size and lands in a small window at the bottom of memory.

Access requests move over a valid/ready stream into a single output register. The unit takes a request in any cycle where `req_ready` is high. `req_ready` is high when the output register is empty or is being emptied in that same cycle. While `acc_valid` is high and `acc_ready` is low, every `acc_*` output holds its value. The stall reaches back to `req_ready` in the same cycle.

Two plain pipelined paths run alongside the stream, each with one cycle of latency. The first takes a 32-bit word returned by the bus and picks out the loaded byte or half-word, right-justified and extended with zeros or with the sign bit. The second clears bit 0 of a fetch or branch-target address.

Top module: `lsu_lane_unit`

## Requirements
- R1: A direct byte access (`req_direct`=1, `req_size`=0) produces an address equal to the 8-bit operand, with all higher bits zero (range 0x000..0x0FF).
- R2: A direct half-word access (`req_size`=1) produces the operand times two (range 0x000..0x1FE, upper bits zero).
- R3: A direct word access (`req_size`=2 or 3) produces the operand times four (range 0x000..0x3FC, upper bits zero). The effective-address input is ignored whenever `req_direct`=1.
- R4: A word access (`req_size` 2, or 3 which is treated as word) from an effective address has address bits 1:0 forced to 00.
- R5: A half-word access from an effective address has address bit 0 forced to 0. A byte access keeps its effective address unchanged.
- R6: `acc_strb` bit 3 selects the byte at offset 0 (bus bits 31:24) and bit 0 the byte at offset 3 (bits 7:0). A write sets one strobe for a byte, two adjacent strobes for a half-word at offset 0 or 2, and all four for a word. A read (`req_write`=0) sets no strobe.
- R7: `acc_wdata` carries the write data big-endian in the addressed lanes: a byte from `req_wdata[7:0]`, a half-word from `req_wdata[15:0]` with its high byte at the lower address, a word unchanged. Lanes not covered are zero.
- R8: When `ret_valid` is high, the next cycle has `ld_valid`=1 and `ld_data` holding the selected byte (offset 0 = bits 31:24) or half-word (offset bit 1 selects bits 15:0), right-justified. It is sign-extended if `ret_signed`=1 and zero-extended otherwise. A word passes unchanged.
- R9: `pc_out` equals the previous cycle's `pc_in` with bit 0 cleared.
- R10: An accepted request appears on `acc_*` with `acc_valid`=1 in the next cycle. `req_ready` = !acc_valid | acc_ready. While `acc_valid`=1 and `acc_ready`=0, the outputs hold.
- R11: During reset `acc_valid`=0, `ld_valid`=0 and `pc_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Unit can take a request |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_direct | input | 1 | Use the direct operand instead of the effective address |
| req_ea | input | 32 | Computed effective address |
| req_dir_op | input | 8 | Direct-address operand |
| req_write | input | 1 | 1 for a store |
| req_wdata | input | 32 | Store data, right-justified |
| acc_valid | output | 1 | Access output valid |
| acc_ready | input | 1 | Downstream takes the access |
| acc_addr | output | 32 | Aligned data address |
| acc_strb | output | 4 | Byte write strobes, bit 3 = offset 0 |
| acc_wdata | output | 32 | Lane-steered store data |
| acc_write | output | 1 | Access is a store |
| pc_in | input | 32 | Fetch or branch-target address |
| pc_out | output | 32 | Even fetch address |
| ret_valid | input | 1 | Returned load word valid |
| ret_word | input | 32 | Returned bus word |
| ret_size | input | 2 | Load size, same encoding as req_size |
| ret_offset | input | 2 | Low address bits of the load |
| ret_signed | input | 1 | 1 for sign extension |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench goes after the edges of the direct window: operand 0xFF at every size, and a direct access with an all-ones effective address. A unit that shifted by the wrong amount or leaked the effective address would show upper address bits or a wrong maximum. It sends odd and misaligned effective addresses at each size. Clearing too few bits leaves the address misaligned, and clearing too many moves a byte access. It checks lane offset 3 against offset 0 for strobes, store data and load extraction, where a little-endian lane order would show up as mirrored strobes or swapped bytes. Loads with bit 7 or bit 15 set and `ret_signed` both low and high catch a wrong or missing extension. Random traffic under a stalling `acc_ready` catches an output that changes while held or a request that is dropped or duplicated.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int BUS_W  = BYTE_W * LANES;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3   // handled as a word
  } acc_size_e;

  // number of low address bits fixed by the access size
  function automatic int unsigned size_log2(acc_size_e s);
    case (s)
      SZ_BYTE: return 0;
      SZ_HALF: return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIR_W  = 8
) (
  input  acc_size_e         size,
  input  logic              direct,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DIR_W-1:0]  dir_op,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - DIR_W;

  logic [ADDR_W-1:0] dir_ext;
  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] keep_mask;

  always_comb begin
    dir_ext   = {{PAD_W{1'b0}}, dir_op};
    raw       = direct ? (dir_ext << size_log2(size)) : ea;
    keep_mask = '1 << size_log2(size);
    addr      = raw & keep_mask;
  end
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
  import lsu_pkg::*;
(
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   offset,
  input  logic               write,
  input  logic [BUS_W-1:0]   wdata,
  output logic [LANES-1:0]   strb,
  output logic [BUS_W-1:0]   lanes
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = BUS_W - 1 - BYTE_W * g;
    localparam logic [OFF_W-1:0] GI = OFF_W'(g);
    logic              covered;
    logic [BYTE_W-1:0] bval;

    always_comb begin
      case (size)
        SZ_BYTE: begin
          covered = (offset == GI);
          bval    = wdata[BYTE_W-1:0];
        end
        SZ_HALF: begin
          covered = (offset[1] == GI[1]);
          bval    = GI[0] ? wdata[BYTE_W-1:0] : wdata[2*BYTE_W-1:BYTE_W];
        end
        default: begin
          covered = 1'b1;
          bval    = wdata[HI -: BYTE_W];
        end
      endcase
    end

    assign lanes[HI -: BYTE_W]  = covered ? bval : '0;
    assign strb[LANES - 1 - g]  = covered & write;
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
(
  input  logic [BUS_W-1:0] word,
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] offset,
  input  logic             sgn,
  output logic [BUS_W-1:0] data
);
  logic [BYTE_W-1:0]   b;
  logic [2*BYTE_W-1:0] h;

  always_comb begin
    case (offset)
      2'd0:    b = word[31:24];
      2'd1:    b = word[23:16];
      2'd2:    b = word[15:8];
      default: b = word[7:0];
    endcase
    h = offset[1] ? word[15:0] : word[31:16];
    case (size)
      SZ_BYTE: data = {{(BUS_W-BYTE_W){sgn & b[BYTE_W-1]}}, b};
      SZ_HALF: data = {{(BUS_W-2*BYTE_W){sgn & h[2*BYTE_W-1]}}, h};
      default: data = word;
    endcase
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic              req_direct,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic [DIR_W-1:0]  req_dir_op,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              acc_valid,
  input  logic              acc_ready,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_strb,
  output logic [BUS_W-1:0]  acc_wdata,
  output logic              acc_write,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] pc_out,
  input  logic              ret_valid,
  input  logic [BUS_W-1:0]  ret_word,
  input  logic [1:0]        ret_size,
  input  logic [1:0]        ret_offset,
  input  logic              ret_signed,
  output logic              ld_valid,
  output logic [BUS_W-1:0]  ld_data
);
  localparam int WIN_LSB = DIR_W + 2;

  acc_size_e         size_in, size_q, ret_sz;
  logic [ADDR_W-1:0] addr_n;
  logic [LANES-1:0]  strb_n;
  logic [BUS_W-1:0]  lanes_n, ld_n;
  logic [OFF_W-1:0]  ret_off_al;
  logic              take;

  assign size_in   = acc_size_e'(req_size);
  assign ret_sz    = acc_size_e'(ret_size);
  assign req_ready = !acc_valid || acc_ready;
  assign take      = req_valid && req_ready;
  // a half-word load ignores offset bit 0
  assign ret_off_al = (ret_sz == SZ_HALF) ? {ret_offset[1], 1'b0} : ret_offset;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .DIR_W(DIR_W)) i_addr (
    .size(size_in), .direct(req_direct), .ea(req_ea),
    .dir_op(req_dir_op), .addr(addr_n)
  );

  lsu_lane_steer i_steer (
    .size(size_in), .offset(addr_n[OFF_W-1:0]), .write(req_write),
    .wdata(req_wdata), .strb(strb_n), .lanes(lanes_n)
  );

  lsu_load_align i_ld (
    .word(ret_word), .size(ret_sz), .offset(ret_off_al),
    .sgn(ret_signed), .data(ld_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_addr  <= '0;
      acc_strb  <= '0;
      acc_wdata <= '0;
      acc_write <= 1'b0;
      size_q    <= SZ_BYTE;
    end else if (take) begin
      acc_valid <= 1'b1;
      acc_addr  <= addr_n;
      acc_strb  <= strb_n;
      acc_wdata <= lanes_n;
      acc_write <= req_write;
      size_q    <= size_in;
    end else if (acc_ready) begin
      acc_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_out   <= '0;
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      pc_out   <= {pc_in[ADDR_W-1:1], 1'b0};
      ld_valid <= ret_valid;
      if (ret_valid) ld_data <= ld_n;
    end
  end

  // R6
  strb_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |-> ($countones(acc_strb) == 1 ||
                                  $countones(acc_strb) == 2 ||
                                  $countones(acc_strb) == 4));
  // R6
  read_no_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |-> (acc_strb == '0));
  // R4
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (size_q == SZ_WORD || size_q == SZ_WIDE)) |-> (acc_addr[1:0] == 2'b00));
  // R5
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && size_q == SZ_HALF) |-> !acc_addr[0]);
  // R3
  direct_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_direct) |=> (acc_addr[ADDR_W-1:WIN_LSB] == '0));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_addr) &&
                                   $stable(acc_strb) && $stable(acc_wdata)));
  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> acc_valid);
  // R9
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_out[0]);
  // R8
  ld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> ld_valid);
endmodule

// File: tb/test_lsu_lane_unit.sv
module test_lsu_lane_unit;
  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  strb;
    logic [31:0] wdata;
    logic        wr;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_size = '0;
  logic        req_direct = 1'b0;
  logic [31:0] req_ea = '0;
  logic [7:0]  req_dir_op = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        acc_valid, acc_ready = 1'b1;
  logic [31:0] acc_addr, acc_wdata;
  logic [3:0]  acc_strb;
  logic        acc_write;
  logic [31:0] pc_in = 32'h0000_1235, pc_out;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_word = '0;
  logic [1:0]  ret_size = '0, ret_offset = '0;
  logic        ret_signed = 1'b0;
  logic        ld_valid;
  logic [31:0] ld_data;

  int    checks = 0, errors = 0, cyc = 0;
  bit    stall_en = 1'b0, done = 1'b0;
  item_t q[$];

  lsu_lane_unit i_lsu_lane_unit (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic item_t model(logic [1:0] sz, logic dir, logic [31:0] ea,
                                  logic [7:0] op, logic wr, logic [31:0] wd);
    item_t it;
    logic [31:0] a;
    logic [1:0]  o;
    a = dir ? ({24'd0, op} * (sz == 2'd0 ? 1 : sz == 2'd1 ? 2 : 4)) : ea;
    if (sz >= 2'd2) a[1:0] = 2'b00;
    else if (sz == 2'd1) a[0] = 1'b0;
    o = a[1:0];
    it.addr = a;
    it.wr   = wr;
    case (sz)
      2'd0: begin it.strb = 4'b1000 >> o; it.wdata = {24'd0, wd[7:0]} << (8 * (3 - o)); end
      2'd1: begin it.strb = 4'b1100 >> o; it.wdata = {16'd0, wd[15:0]} << (8 * (2 - o)); end
      default: begin it.strb = 4'b1111; it.wdata = wd; end
    endcase
    if (!wr) it.strb = 4'b0000;
    return it;
  endfunction

  // driver: called just after a falling edge
  task automatic send(logic [1:0] sz, logic dir, logic [31:0] ea, logic [7:0] op,
                      logic wr, logic [31:0] wd);
    #2;
    req_size = sz; req_direct = dir; req_ea = ea; req_dir_op = op;
    req_write = wr; req_wdata = wd; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #3; end
    q.push_back(model(sz, dir, ea, op, wr, wd));
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk("R10", "valid one cycle after accept", {31'd0, acc_valid}, 32'd1);
  endtask

  // monitor: set acc_ready, then compare the item leaving at the next edge
  initial begin
    item_t exp;
    logic        prev_hold = 1'b0;
    logic [31:0] prev_addr = '0;
    forever begin
      @(negedge clk);
      acc_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (prev_hold) begin
          chk("R10", "held valid", {31'd0, acc_valid}, 32'd1);
          chk("R10", "held address", acc_addr, prev_addr);
        end
        if (acc_valid && acc_ready) begin
          if (q.size() == 0) chk("R10", "unexpected output", 32'd1, 32'd0);
          else begin
            exp = q.pop_front();
            chk("R1-R5 addr", "acc_addr", acc_addr, exp.addr);
            chk("R6", "acc_strb", {28'd0, acc_strb}, {28'd0, exp.strb});
            chk("R7", "acc_wdata", acc_wdata, exp.wdata);
            chk("R10", "acc_write", {31'd0, acc_write}, {31'd0, exp.wr});
          end
        end
        prev_hold = acc_valid && !acc_ready;
        prev_addr = acc_addr;
      end
    end
  end

  task automatic load(logic [31:0] w, logic [1:0] sz, logic [1:0] off, logic sg,
                      logic [31:0] exp);
    #2;
    ret_word = w; ret_size = sz; ret_offset = off; ret_signed = sg; ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
    #1;
    chk("R8", "ld_valid", {31'd0, ld_valid}, 32'd1);
    chk("R8", "ld_data", ld_data, exp);
  endtask

  initial begin
    logic [31:0] r;
    // R11 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "acc_valid", {31'd0, acc_valid}, 32'd0);
    chk("R11", "ld_valid", {31'd0, ld_valid}, 32'd0);
    chk("R11", "pc_out", pc_out, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 direct window edges
    send(2'd0, 1'b1, 32'hFFFF_FFFF, 8'hFF, 1'b1, 32'h1122_3344);
    send(2'd1, 1'b1, 32'hFFFF_FFFF, 8'hFF, 1'b1, 32'h1122_3344);
    send(2'd2, 1'b1, 32'hFFFF_FFFF, 8'hFF, 1'b1, 32'h1122_3344);
    send(2'd3, 1'b1, 32'h1234_5678, 8'h01, 1'b1, 32'hA1B2_C3D4);
    send(2'd0, 1'b1, 32'h0, 8'h58, 1'b0, 32'h0000_00AA);
    // R4 R5 misaligned effective addresses
    send(2'd2, 1'b0, 32'h0004_1237, 8'h00, 1'b1, 32'hDEAD_BEEF);
    send(2'd1, 1'b0, 32'h0004_1237, 8'h00, 1'b1, 32'h0000_CAFE);
    send(2'd1, 1'b0, 32'h0004_1235, 8'h00, 1'b1, 32'h0000_BEAD);
    send(2'd0, 1'b0, 32'h0004_1235, 8'h00, 1'b1, 32'h0000_0044);
    send(2'd0, 1'b0, 32'h0004_1234, 8'h00, 1'b1, 32'h0000_0077);
    send(2'd3, 1'b0, 32'h8000_0003, 8'h00, 1'b0, 32'h0);

    // random traffic with back-pressure (R10)
    stall_en = 1'b1;
    r = 32'h1357_9BDF;
    for (int i = 0; i < 60; i++) begin
      r = r * 32'd1103515245 + 32'd12345;
      send(r[17:16], r[20], r ^ 32'h5A5A_1234, r[31:24], r[22], {r[15:0], r[31:16]});
    end
    for (int i = 0; i < 40 && q.size() != 0; i++) @(negedge clk);
    stall_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "scoreboard drained", q.size(), 32'd0);

    // R8 load extraction
    load(32'h80FF_7F01, 2'd0, 2'd0, 1'b1, 32'hFFFF_FF80);
    load(32'h80FF_7F01, 2'd0, 2'd0, 1'b0, 32'h0000_0080);
    load(32'h80FF_7F01, 2'd0, 2'd3, 1'b1, 32'h0000_0001);
    load(32'h80FF_7F01, 2'd0, 2'd2, 1'b1, 32'h0000_007F);
    load(32'h1234_8001, 2'd1, 2'd2, 1'b1, 32'hFFFF_8001);
    load(32'h1234_8001, 2'd1, 2'd3, 1'b0, 32'h0000_8001);
    load(32'h9234_0001, 2'd1, 2'd0, 1'b1, 32'hFFFF_9234);
    load(32'h9234_0001, 2'd2, 2'd1, 1'b1, 32'h9234_0001);
    #2;
    @(negedge clk);
    #1 chk("R8", "ld_valid drops", {31'd0, ld_valid}, 32'd0);

    // R9 fetch alignment
    #1 pc_in = 32'hFFFF_FFFF;
    @(negedge clk);
    #1 chk("R9", "pc_out odd in", pc_out, 32'hFFFF_FFFE);
    #1 pc_in = 32'h0010_0002;
    @(negedge clk);
    #1 chk("R9", "pc_out even in", pc_out, 32'h0010_0002);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule